// File: doc/BRIEF.md
# Packed-Field Real-Time Counter with Event Flags

This block keeps wall-clock time at one-second resolution in a single 32-bit word. The word is split into separate second, minute, hour and day fields, and each field rolls over on its own. The block runs from a slow reference clock, nominally 32.768 kHz. A prescaler, switched on and off through a register, divides that clock down to one advance per second. When the prescaler is off, the time advances on every reference clock, which is useful for fast bring-up and test.

Alongside the time, the block holds an alarm word, a down-counting stopwatch, a set of sticky event flags and an interrupt mask. The flags record:

- every second advance
- each minute, hour and day rollover
- a time-of-day alarm
- a day-and-time alarm
- stopwatch expiry

Each flag is cleared by writing one to it. The interrupt output is the OR of the flags that are both set and enabled in the mask. Software reaches the registers through a simple valid/write/address/data port. Reads are combinational from the address. The current time word is also driven continuously on its own output.

Top module: `rtc_field_counter`

## Requirements
- R1: After reset, the following are all zero: the time word, the alarm word, the stopwatch, the mask, the status flags and the prescaler enable; the interrupt output is low.
- R2: The time word holds seconds in bits [5:0], minutes in [11:6], hours in [16:12] and days in [31:17]. On an advance, seconds step by one; a seconds value of 59 or more wraps to 0 and carries into minutes. Minutes wrap the same way at 59 or more and carry into hours. Hours wrap at 23 or more and increment the 15-bit day field, which wraps naturally.
- R3: With the prescaler enable at 1, the time advances exactly once every PRESC_DIV (default 32768) clocks. With the enable at 0, it advances on every clock.
- R4: A write to the time register loads the whole word at the next edge. In that cycle it takes priority over any advance, and no second, rollover or alarm event is raised for that cycle.
- R5: A status flag sets when its event occurs, whatever the mask says. The irq output is high exactly when some flag is set and its mask bit (same bit position) is 1.
- R6: Writing the status register clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. If an event for a flag occurs in the same cycle as its clear, the flag stays set.
- R7: Two alarm flags compare the alarm word with the time word that results from an advance. Status bit 1 sets when the seconds, minutes and hours match, whatever the day fields hold. Status bit 6 sets only when all four fields match.
- R8: The stopwatch holds a 16-bit value. On each advance it counts down by one while it is nonzero. It sets status bit 0 on the step that reaches zero. A value of zero stays at zero and raises no flag. A write to the stopwatch takes priority over a decrement in the same cycle.
- R9: The rollover flags are status bit 2 (set on every advance), bit 3 (seconds wrap), bit 4 (minutes wrap) and bit 5 (hours wrap, which is also the day increment).
- R10: The register addresses are: 0 time, 1 alarm, 2 stopwatch (low 16 bits), 3 mask (bits [6:0]), 4 status (bits [6:0], write one to clear), 5 prescaler enable (bit 0). Reads return the current register value, zero-extended. Addresses 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr (combinational) |
| time_now | output | 32 | Current packed time word |
| irq | output | 1 | OR of the flags that are both set and enabled |

## Verification
The assertions assume three things about the inputs: reset is held high from time zero through the first edges; the prescaler divisor is at least two; and the write data and address are stable around each clock edge. A write that lands in the same cycle as an advance is treated as legal input, not excluded. The stimulus drives every input on the falling edge. It holds reset for three edges before the first access. It deliberately times one status clear to coincide with an advance, and it loads one out-of-range seconds value, so that the priority and wrap rules are exercised rather than assumed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 15;
    localparam int WORD_W = SEC_W + MIN_W + HR_W + DAY_W;

    localparam int SEC_LIM = 60;
    localparam int MIN_LIM = 60;
    localparam int HR_LIM  = 24;

    localparam int NUM_EV = 7;
    localparam int ADDR_W = 3;

    // event flag positions
    localparam int EV_SW   = 0;
    localparam int EV_ALM  = 1;
    localparam int EV_SEC  = 2;
    localparam int EV_MIN  = 3;
    localparam int EV_HR   = 4;
    localparam int EV_DAY  = 5;
    localparam int EV_DALM = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_TIME   = 3'd0,
        RA_ALARM  = 3'd1,
        RA_SWATCH = 3'd2,
        RA_MASK   = 3'd3,
        RA_STATUS = 3'd4,
        RA_PRESC  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [DAY_W-1:0] days;
        logic [HR_W-1:0]  hours;
        logic [MIN_W-1:0] mins;
        logic [SEC_W-1:0] secs;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t t;
        logic      sec_wrap;
        logic      min_wrap;
        logic      hr_wrap;
    } step_t;

    // one-second advance with per-field rollover
    function automatic step_t step_time(rtc_time_t cur);
        step_t r;
        r.t        = cur;
        r.sec_wrap = 1'b0;
        r.min_wrap = 1'b0;
        r.hr_wrap  = 1'b0;
        if (cur.secs >= SEC_W'(SEC_LIM - 1)) begin
            r.t.secs   = '0;
            r.sec_wrap = 1'b1;
            if (cur.mins >= MIN_W'(MIN_LIM - 1)) begin
                r.t.mins   = '0;
                r.min_wrap = 1'b1;
                if (cur.hours >= HR_W'(HR_LIM - 1)) begin
                    r.t.hours = '0;
                    r.hr_wrap = 1'b1;
                    r.t.days  = cur.days + 1'b1;
                end else begin
                    r.t.hours = cur.hours + 1'b1;
                end
            end else begin
                r.t.mins = cur.mins + 1'b1;
            end
        end else begin
            r.t.secs = cur.secs + 1'b1;
        end
        return r;
    endfunction

    function automatic logic tod_match(rtc_time_t a, rtc_time_t b);
        return (a.secs == b.secs) && (a.mins == b.mins) && (a.hours == b.hours);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(DIV - 1));
    assign tick = en ? wrap : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // two slow ticks are never adjacent when the divider is active
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && tick && $past(en)) |=> !(en && tick));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t time_q,
    output rtc_time_t adv_time,
    output logic      adv,
    output logic      ev_sec,
    output logic      ev_min,
    output logic      ev_hr,
    output logic      ev_day
);
    step_t st;

    assign st       = step_time(time_q);
    assign adv      = tick & ~load;
    assign adv_time = st.t;
    assign ev_sec   = adv;
    assign ev_min   = adv & st.sec_wrap;
    assign ev_hr    = adv & st.min_wrap;
    assign ev_day   = adv & st.hr_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
        end else if (load) begin
            time_q <= load_val;
        end else if (tick) begin
            time_q <= st.t;
        end
    end

    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && time_q.secs >= SEC_W'(SEC_LIM - 1)) |=> (time_q.secs == '0));

    p_day_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && time_q.secs >= SEC_W'(SEC_LIM - 1) && time_q.mins >= MIN_W'(MIN_LIM - 1)
             && time_q.hours >= HR_W'(HR_LIM - 1))
        |=> (time_q.days == $past(time_q.days) + 1'b1) && (time_q.hours == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(time_q));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (time_q == $past(load_val)));

endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
    import rtc_pkg::*;
#(
    parameter int SW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              adv,
    input  rtc_time_t         adv_time,
    input  rtc_time_t         alarm,
    input  logic              ev_sec,
    input  logic              ev_min,
    input  logic              ev_hr,
    input  logic              ev_day,
    input  logic              sw_load,
    input  logic [SW_W-1:0]   sw_val,
    input  logic [NUM_EV-1:0] clr,
    output logic [SW_W-1:0]   sw_q,
    output logic [NUM_EV-1:0] status_q
);
    logic              sw_done;
    logic              tod_hit;
    logic              day_hit;
    logic [NUM_EV-1:0] ev;

    assign sw_done = tick & ~sw_load & (sw_q == SW_W'(1));
    assign tod_hit = adv & tod_match(adv_time, alarm);
    assign day_hit = tod_hit & (adv_time.days == alarm.days);

    always_comb begin
        ev          = '0;
        ev[EV_SW]   = sw_done;
        ev[EV_ALM]  = tod_hit;
        ev[EV_SEC]  = ev_sec;
        ev[EV_MIN]  = ev_min;
        ev[EV_HR]   = ev_hr;
        ev[EV_DAY]  = ev_day;
        ev[EV_DALM] = day_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else if (sw_load) begin
            sw_q <= sw_val;
        end else if (tick && sw_q != '0) begin
            sw_q <= sw_q - 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= (flag_q & ~clr[i]) | ev[i];
            end
        end
        assign status_q[i] = flag_q;

        p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !clr[i]) |=> flag_q);

        p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !ev[i]) |=> !flag_q);
    end

    p_full_match_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && adv_time == alarm) |=> (status_q[EV_ALM] && status_q[EV_DALM]));

    p_sw_expire_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw_load && sw_q == SW_W'(1)) |=> (sw_q == '0 && status_q[EV_SW]));

    p_sw_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!sw_load && sw_q == '0) |=> (sw_q == '0));

endmodule

// File: rtl/rtc_field_counter.sv
module rtc_field_counter
    import rtc_pkg::*;
#(
    parameter int PRESC_DIV = 32768,
    parameter int SW_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] time_now,
    output logic              irq
);
    logic              we;
    logic              tick;
    logic              pren_q;
    rtc_time_t         alarm_q;
    logic [NUM_EV-1:0] mask_q;
    rtc_time_t         time_q;
    rtc_time_t         adv_time;
    logic              adv;
    logic              ev_sec, ev_min, ev_hr, ev_day;
    logic [SW_W-1:0]   sw_q;
    logic [NUM_EV-1:0] status_q;
    logic [NUM_EV-1:0] clr;
    logic              load_time;
    logic              load_sw;

    assign we        = req_valid & req_write;
    assign load_time = we && (req_addr == RA_TIME);
    assign load_sw   = we && (req_addr == RA_SWATCH);
    assign clr       = (we && req_addr == RA_STATUS) ? req_wdata[NUM_EV-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            mask_q  <= '0;
            pren_q  <= 1'b0;
        end else if (we) begin
            case (req_addr)
                RA_ALARM: alarm_q <= rtc_time_t'(req_wdata);
                RA_MASK:  mask_q  <= req_wdata[NUM_EV-1:0];
                RA_PRESC: pren_q  <= req_wdata[0];
                default:  ;
            endcase
        end
    end

    rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (pren_q),
        .tick (tick)
    );

    rtc_timekeeper u_time (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load_time),
        .load_val (rtc_time_t'(req_wdata)),
        .time_q   (time_q),
        .adv_time (adv_time),
        .adv      (adv),
        .ev_sec   (ev_sec),
        .ev_min   (ev_min),
        .ev_hr    (ev_hr),
        .ev_day   (ev_day)
    );

    rtc_event_unit #(.SW_W(SW_W)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .adv      (adv),
        .adv_time (adv_time),
        .alarm    (alarm_q),
        .ev_sec   (ev_sec),
        .ev_min   (ev_min),
        .ev_hr    (ev_hr),
        .ev_day   (ev_day),
        .sw_load  (load_sw),
        .sw_val   (req_wdata[SW_W-1:0]),
        .clr      (clr),
        .sw_q     (sw_q),
        .status_q (status_q)
    );

    always_comb begin
        case (req_addr)
            RA_TIME:   rd_data = time_q;
            RA_ALARM:  rd_data = alarm_q;
            RA_SWATCH: rd_data = WORD_W'(sw_q);
            RA_MASK:   rd_data = WORD_W'(mask_q);
            RA_STATUS: rd_data = WORD_W'(status_q);
            RA_PRESC:  rd_data = WORD_W'(pren_q);
            default:   rd_data = '0;
        endcase
    end

    assign time_now = time_q;
    assign irq      = |(status_q & mask_q);

    // a newly set, enabled flag raises the interrupt in the cycle it appears
    p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
        (mask_q[EV_SEC] && adv && !(we && req_addr == RA_MASK)) |=> irq);

endmodule

// File: tb/rtc_field_counter_tb_top.sv
module rtc_field_counter_tb_top;

    localparam int DIV = 32768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] rd_data;
    logic [31:0] time_now;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_field_counter #(.PRESC_DIV(DIV), .SW_W(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .time_now  (time_now),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [5:0]  m_sec = 0, m_min = 0;
    logic [4:0]  m_hr = 0;
    logic [14:0] m_day = 0;
    logic [31:0] m_alarm = 0;
    logic [15:0] m_sw = 0;
    logic [6:0]  m_mask = 0, m_stat = 0;
    logic        m_pren = 0;
    int          m_pcnt = 0;

    function automatic logic [31:0] tw(int d, int h, int m, int s);
        return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
    endfunction

    function automatic logic [31:0] m_word();
        return {m_day, m_hr, m_min, m_sec};
    endfunction

    always @(posedge clk) begin
        logic       we, tk;
        logic [6:0] ev, clr;
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
            m_alarm = 0; m_sw = 0; m_mask = 0; m_stat = 0;
            m_pren = 0; m_pcnt = 0;
        end else begin
            we = req_valid && req_write;
            tk = m_pren ? (m_pcnt == DIV - 1) : 1'b1;
            if (!m_pren || tk) m_pcnt = 0;
            else m_pcnt = m_pcnt + 1;
            ev = 0;
            if (we && req_addr == 3'd0) begin
                {m_day, m_hr, m_min, m_sec} = req_wdata;
            end else if (tk) begin
                ev[2] = 1'b1;
                if (m_sec >= 59) begin
                    m_sec = 0; ev[3] = 1'b1;
                    if (m_min >= 59) begin
                        m_min = 0; ev[4] = 1'b1;
                        if (m_hr >= 23) begin
                            m_hr = 0; ev[5] = 1'b1; m_day = m_day + 1;
                        end else m_hr = m_hr + 1;
                    end else m_min = m_min + 1;
                end else m_sec = m_sec + 1;
                if (m_word()[16:0] == m_alarm[16:0]) begin
                    ev[1] = 1'b1;
                    if (m_day == m_alarm[31:17]) ev[6] = 1'b1;
                end
            end
            if (we && req_addr == 3'd2) m_sw = req_wdata[15:0];
            else if (tk && m_sw != 0) begin
                m_sw = m_sw - 1;
                if (m_sw == 0) ev[0] = 1'b1;
            end
            clr = (we && req_addr == 3'd4) ? req_wdata[6:0] : 7'd0;
            m_stat = (m_stat & ~clr) | ev;
            if (we && req_addr == 3'd1) m_alarm = req_wdata;
            if (we && req_addr == 3'd3) m_mask = req_wdata[6:0];
            if (we && req_addr == 3'd5) m_pren = req_wdata[0];
        end
    end

    // per-cycle comparison of the continuously visible outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (time_now !== m_word() || irq !== |(m_stat & m_mask)) begin
                errors++;
                $display("FAIL R2/R5 cycle compare: time %h irq %b expected time %h irq %b",
                         time_now, irq, m_word(), |(m_stat & m_mask));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        req_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, t0;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, read before the first advance
        rd(3'd0, v); chk("R1 time after reset", v, 0);
        rd(3'd1, v); chk("R1 alarm after reset", v, 0);
        rd(3'd2, v); chk("R1 stopwatch after reset", v, 0);
        rd(3'd3, v); chk("R1 mask after reset", v, 0);
        rd(3'd4, v); chk("R1 status after reset", v, 0);
        rd(3'd5, v); chk("R1 prescaler after reset", v, 0);
        chk("R1 irq after reset", 32'(irq), 0);
        @(negedge clk);

        // R10: unused addresses
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); chk("R10 unused address reads zero", v, 0);
        rd(3'd7, v); chk("R10 unused address 7 reads zero", v, 0);
        rd(3'd3, v); chk("R10 mask untouched by unused write", v, 0);
        rd(3'd1, v); chk("R10 alarm untouched by unused write", v, 0);

        // R2, R9, R7, R6: midnight crossing with fast ticks
        wr(3'd3, 32'h3E);
        wr(3'd0, tw(5, 23, 59, 58));
        wr(3'd4, 32'h7F);
        rd(3'd4, v); chk("R6 event wins over same-cycle clear", v, 32'h04);
        rd(3'd0, v); chk("R2 seconds step", v, tw(5, 23, 59, 59));
        @(negedge clk);
        rd(3'd0, v); chk("R2 day increments on hour wrap", v, tw(6, 0, 0, 0));
        rd(3'd4, v); chk("R9 rollover flags and R7 time alarm", v, 32'h3E);
        chk("R7 day alarm not set on other day", 32'(v[6]), 0);
        chk("R5 irq with enabled flags", 32'(irq), 1);

        // R2: out-of-range seconds wrap
        wr(3'd0, tw(0, 0, 0, 62));
        @(negedge clk);
        rd(3'd0, v); chk("R2 out-of-range seconds wrap", v, tw(0, 0, 1, 0));

        // R8: stopwatch
        wr(3'd4, 32'h7F);
        wr(3'd2, 32'd3);
        rd(3'd2, v); chk("R8 stopwatch load", v, 3);
        @(negedge clk);
        @(negedge clk);
        rd(3'd2, v); chk("R8 stopwatch counting", v, 1);
        rd(3'd4, v); chk("R8 no flag before zero", 32'(v[0]), 0);
        @(negedge clk);
        rd(3'd2, v); chk("R8 stopwatch reached zero", v, 0);
        rd(3'd4, v); chk("R8 expiry flag", 32'(v[0]), 1);
        wr(3'd2, 32'd0);
        wr(3'd4, 32'h01);
        repeat (5) @(negedge clk);
        rd(3'd2, v); chk("R8 zero stays zero", v, 0);
        rd(3'd4, v); chk("R8 zero raises no flag", 32'(v[0]), 0);

        // R7: day alarm matched
        wr(3'd4, 32'h7F);
        wr(3'd1, tw(7, 0, 0, 5));
        wr(3'd0, tw(7, 0, 0, 0));
        repeat (5) @(negedge clk);
        rd(3'd0, v); chk("R7 time at alarm", v, tw(7, 0, 0, 5));
        rd(3'd4, v); chk("R7 both alarm flags on full match", v & 32'h42, 32'h42);

        // R7: time alarm ignoring day
        wr(3'd1, tw(9, 0, 0, 5));
        wr(3'd0, tw(7, 0, 0, 0));
        wr(3'd4, 32'h7F);
        repeat (4) @(negedge clk);
        rd(3'd4, v); chk("R7 time alarm only when day differs", v & 32'h42, 32'h02);

        // R3, R5, R6, R4: prescaled operation
        wr(3'd5, 32'd1);
        wr(3'd3, 32'h02);
        wr(3'd4, 32'h7F);
        rd(3'd4, v); chk("R6 clear all flags", v, 0);
        rd(3'd5, v); chk("R10 prescaler enable readback", v, 1);
        t0 = time_now;
        while (time_now == t0) @(negedge clk);
        t0 = time_now;
        n = 0;
        while (time_now == t0 && n < DIV + 10) begin
            @(negedge clk);
            n++;
        end
        chk("R3 prescaled advance period", n, DIV);
        rd(3'd4, v); chk("R5 flag sets while masked off", 32'(v[2]), 1);
        chk("R5 irq gated by mask", 32'(irq), 0);
        wr(3'd3, 32'h04);
        chk("R5 irq once mask enables flag", 32'(irq), 1);
        wr(3'd4, 32'h00);
        rd(3'd4, v); chk("R6 writing zero leaves flag", 32'(v[2]), 1);
        wr(3'd4, 32'h04);
        rd(3'd4, v); chk("R6 write one clears flag", v, 0);
        chk("R6 irq drops after clear", 32'(irq), 0);
        wr(3'd1, tw(0, 1, 2, 3));
        wr(3'd0, tw(0, 1, 2, 3));
        rd(3'd0, v); chk("R4 time load", v, tw(0, 1, 2, 3));
        rd(3'd4, v); chk("R4 load raises no alarm or second flag", v, 0);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R3 no advance between slow ticks", v, tw(0, 1, 2, 3));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule